// File: doc/BRIEF.md
# Ping-Pong Reference-Subtraction Stream Processor

The block accepts 160-bit stream beats, each carrying a time stamp, a channel number, a reference channel number, a hash word, a threshold and a 32-bit signed sample. Every accepted sample goes into a per-channel buffer with two banks. The low bit of the time stamp picks the bank. In the same beat, the other bank, which holds the previous time step, is read at two addresses: the beat's channel and its reference channel. The block then forms the re-referenced value.

One result beat leaves on the output stream for each accepted input beat whose time stamp is non-zero. The result beat uses the same layout as the input. The sample field is replaced by the re-referenced value from the previous time step, and the time stamp is lowered by one. A single output register holds the pending result. The input is stalled while that register is full and is not being drained, so no beat is ever lost under backpressure.

Top module: `refsub_stream`

## Requirements
- R1: Output fields hash [95:64], threshold [63:32], channel [107:96] and reference channel [119:108] equal those of the input beat that produced the output beat. Output bits [127:120] are always zero.
- R2: The output time stamp [159:128] equals the input time stamp minus one.
- R3: An accepted input beat with time stamp 0 produces no output beat.
- R4: An accepted sample is written to bank (time stamp bit 0) at its channel. The value read for the output comes from the opposite bank, so it is the sample stored for that channel during the previous time step of the other parity.
- R5: When the reference channel is below NUM_CH (160), the output value is the channel's previous-step value minus the reference channel's previous-step value. The subtraction wraps modulo 2^32.
- R6: When the reference channel is NUM_CH or above, the output value is the channel's previous-step value unchanged.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable.
- R8: in_ready is high exactly when the output register is empty or is being drained in that cycle. Each accepted beat with a non-zero time stamp appears as an output beat in the next cycle, so nothing is lost.
- R9: A synchronous active-high reset clears out_valid and leaves in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_data | input | 160 | Input beat |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream accepts result beat |
| out_data | output | 160 | Result beat |

## Verification
The bench runs several time steps of alternating parity. It checks that each result uses the opposite bank, so a design that read the bank being written would return the current sample rather than the earlier one. The reference channel is exercised at a low index, at the channel itself (result zero), at exactly NUM_CH and at the all-ones value. An off-by-one limit would subtract an unwritten entry where the value should pass through. A wrap from 0x80000000 minus one catches saturating or widened arithmetic, and a time stamp of 0xFFFFFFFF checks the decrement at the top of the range. Held backpressure with a second beat waiting would expose a design that overwrites its pending result or accepts the waiting beat early. A reset during a pending result must drop it.

// File: rtl/refsub_pkg.sv
package refsub_pkg;

    localparam int TS_W   = 32;
    localparam int PAD_W  = 8;
    localparam int CH_W   = 12;
    localparam int HASH_W = 32;
    localparam int THR_W  = 32;
    localparam int VAL_W  = 32;
    localparam int BEAT_W = TS_W + PAD_W + 2 * CH_W + HASH_W + THR_W + VAL_W;

    // Field order, MSB first, is the wire layout of a beat.
    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [PAD_W-1:0]  pad;
        logic [CH_W-1:0]   rf;
        logic [CH_W-1:0]   ch;
        logic [HASH_W-1:0] hash;
        logic [THR_W-1:0]  thr;
        logic [VAL_W-1:0]  val;
    } beat_t;

    typedef struct packed {
        logic  vld;
        beat_t beat;
    } ostate_t;

endpackage

// File: rtl/refsub_decode.sv
module refsub_decode
    import refsub_pkg::*;
#(
    parameter int NUM_CH = 160,
    parameter int IDX_W  = 8
) (
    input  logic             ts_lsb,
    input  logic [CH_W-1:0]  ch,
    input  logic [CH_W-1:0]  rf,
    output logic             wr_bank,
    output logic             rd_bank,
    output logic             ch_ok,
    output logic             ref_ok,
    output logic [IDX_W-1:0] ch_idx,
    output logic [IDX_W-1:0] ref_idx
);
    localparam logic [CH_W-1:0] LIMIT = CH_W'(NUM_CH);

    always_comb begin
        wr_bank = ts_lsb;
        rd_bank = ~ts_lsb;
        ch_ok   = (ch < LIMIT);
        ref_ok  = (rf < LIMIT);
        // Out-of-range indices are parked at entry 0 so no read leaves the array.
        ch_idx  = ch_ok  ? ch[IDX_W-1:0] : '0;
        ref_idx = ref_ok ? rf[IDX_W-1:0] : '0;
    end

endmodule

// File: rtl/refsub_bank.sv
module refsub_bank
    import refsub_pkg::*;
#(
    parameter int NUM_CH = 160,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VAL_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [VAL_W-1:0] rd_a,
    output logic [VAL_W-1:0] rd_b
);
    logic [VAL_W-1:0] mem_q [NUM_CH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_val;
        end
    end

    assign rd_a = mem_q[rd_idx_a];
    assign rd_b = mem_q[rd_idx_b];

endmodule

// File: rtl/refsub_calc.sv
module refsub_calc
    import refsub_pkg::*;
(
    input  beat_t            in_beat,
    input  logic             ch_ok,
    input  logic             ref_ok,
    input  logic [VAL_W-1:0] ch_val,
    input  logic [VAL_W-1:0] ref_val,
    output beat_t            out_beat
);
    logic [VAL_W-1:0] diff;

    always_comb begin
        diff         = ch_val - ref_val;
        out_beat     = in_beat;
        out_beat.pad = '0;
        out_beat.ts  = in_beat.ts - TS_W'(1);
        if (!ch_ok) begin
            out_beat.val = '0;
        end else if (ref_ok) begin
            out_beat.val = diff;
        end else begin
            out_beat.val = ch_val;
        end
    end

endmodule

// File: rtl/refsub_stream.sv
module refsub_stream
    import refsub_pkg::*;
#(
    parameter int NUM_CH = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data
);
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int N_BANKS = 2;

    beat_t            in_beat;
    beat_t            res_beat;
    logic             wr_bank, rd_bank, ch_ok, ref_ok;
    logic [IDX_W-1:0] ch_idx, ref_idx;
    logic [VAL_W-1:0] rd_ch  [N_BANKS];
    logic [VAL_W-1:0] rd_ref [N_BANKS];
    logic [VAL_W-1:0] ch_val, ref_val;
    logic             in_fire, emit;
    ostate_t          st_d, st_q;

    assign in_beat  = beat_t'(in_data);
    assign in_ready = !st_q.vld || out_ready;
    assign in_fire  = in_valid && in_ready;
    assign emit     = (in_beat.ts != '0);

    refsub_decode #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_decode (
        .ts_lsb  (in_beat.ts[0]),
        .ch      (in_beat.ch),
        .rf      (in_beat.rf),
        .wr_bank (wr_bank),
        .rd_bank (rd_bank),
        .ch_ok   (ch_ok),
        .ref_ok  (ref_ok),
        .ch_idx  (ch_idx),
        .ref_idx (ref_idx)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        refsub_bank #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_bank (
            .clk      (clk),
            .wr_en    (in_fire && ch_ok && (wr_bank == 1'(b))),
            .wr_idx   (ch_idx),
            .wr_val   (in_beat.val),
            .rd_idx_a (ch_idx),
            .rd_idx_b (ref_idx),
            .rd_a     (rd_ch[b]),
            .rd_b     (rd_ref[b])
        );
    end

    assign ch_val  = rd_ch[rd_bank];
    assign ref_val = rd_ref[rd_bank];

    refsub_calc u_calc (
        .in_beat  (in_beat),
        .ch_ok    (ch_ok),
        .ref_ok   (ref_ok),
        .ch_val   (ch_val),
        .ref_val  (ref_val),
        .out_beat (res_beat)
    );

    always_comb begin
        st_d = st_q;
        if (out_ready) begin
            st_d.vld = 1'b0;
        end
        if (in_fire && emit) begin
            st_d.vld  = 1'b1;
            st_d.beat = res_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.beat;

    // R7: a stalled result keeps its valid and data
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8: an accepted non-zero-time beat is presented next cycle
    p_no_loss_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_data[159:128] != '0) |=> out_valid);

    // R3: time-zero beats yield nothing
    p_ts_zero_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_data[159:128] == '0) |=> !out_valid);

    // R2: time stamp lowered by one
    p_ts_dec_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_data[159:128] != '0)
        |=> out_data[159:128] == $past(in_data[159:128]) - 32'd1);

    // R1: pad bits are zero on a valid result
    p_pad_zero_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data[127:120] == '0);

    // R9: reset empties the output register
    p_reset_r9: assert property (@(posedge clk) rst |=> !out_valid);

endmodule

// File: tb/refsub_stream_tb.sv
`timescale 1ns/1ps
module refsub_stream_tb;
    import refsub_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [BEAT_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [BEAT_W-1:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    refsub_stream u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    typedef struct packed {
        logic [31:0] ts;
        logic [11:0] ch;
        logic [11:0] rf;
        logic [31:0] v;
        logic        ev;
        logic [31:0] ex;
        logic [3:0]  req;   // 4 = bank/R4, 5 = subtract/R5, 6 = pass/R6
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{32'd0, 12'd0,   12'hFFF, 32'd100,        1'b0, 32'd0,          4'd3},
        '{32'd0, 12'd1,   12'hFFF, 32'd30,         1'b0, 32'd0,          4'd3},
        '{32'd0, 12'd2,   12'hFFF, 32'hFFFF_FFFB,  1'b0, 32'd0,          4'd3},
        '{32'd0, 12'd3,   12'hFFF, 32'd7,          1'b0, 32'd0,          4'd3},
        '{32'd0, 12'd159, 12'hFFF, 32'd9,          1'b0, 32'd0,          4'd3},
        '{32'd1, 12'd0,   12'd1,   32'd11,         1'b1, 32'd70,         4'd5},
        '{32'd1, 12'd1,   12'hFFF, 32'd22,         1'b1, 32'd30,         4'd6},
        '{32'd1, 12'd2,   12'd0,   32'd33,         1'b1, 32'hFFFF_FF97,  4'd5},
        '{32'd1, 12'd3,   12'd160, 32'd44,         1'b1, 32'd7,          4'd6},
        '{32'd1, 12'd3,   12'd3,   32'd55,         1'b1, 32'd0,          4'd5},
        '{32'd1, 12'd159, 12'hFFF, 32'd12,         1'b1, 32'd9,          4'd6},
        '{32'd2, 12'd0,   12'd2,   32'h8000_0000,  1'b1, 32'hFFFF_FFEA,  4'd4},
        '{32'd2, 12'd1,   12'd3,   32'd1,          1'b1, 32'hFFFF_FFDF,  4'd4},
        '{32'd3, 12'd0,   12'd1,   32'd0,          1'b1, 32'h7FFF_FFFF,  4'd5},
        '{32'hFFFF_FFFF, 12'd1, 12'hFFF, 32'd2,    1'b1, 32'd1,          4'd4}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [BEAT_W-1:0] mk(input logic [31:0] ts,
            input logic [11:0] ch, input logic [11:0] rf, input logic [31:0] v,
            input int i);
        beat_t b;
        b.ts   = ts;
        b.pad  = 8'hFF;
        b.rf   = rf;
        b.ch   = ch;
        b.hash = 32'hA500_0000 + 32'(i);
        b.thr  = 32'h0001_0003 * 32'(i);
        b.val  = v;
        return b;
    endfunction

    task automatic check_out(input logic [BEAT_W-1:0] sent, input logic [31:0] ex,
                             input string vreq);
        beat_t s, o;
        s = beat_t'(sent);
        o = beat_t'(out_data);
        chk(out_valid === 1'b1, "R8 valid", 32'(out_valid), 32'd1);
        chk(o.val === ex, vreq, o.val, ex);
        chk(o.ts === s.ts - 32'd1, "R2 ts", o.ts, s.ts - 32'd1);
        chk(o.hash === s.hash && o.thr === s.thr, "R1 hash/thr", o.hash, s.hash);
        chk(o.ch === s.ch && o.rf === s.rf, "R1 ch/ref", {8'd0, o.ch, o.rf},
            {8'd0, s.ch, s.rf});
        chk(o.pad === 8'h00, "R1 pad", 32'(o.pad), 32'd0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [BEAT_W-1:0] snap;
        logic [BEAT_W-1:0] sent;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(out_valid === 1'b0, "R9 out_valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready === 1'b1, "R9 in_ready after reset", 32'(in_ready), 32'd1);

        // Table walk, out_ready held high
        for (int i = 0; i < NV; i++) begin
            sent     = mk(VEC[i].ts, VEC[i].ch, VEC[i].rf, VEC[i].v, i);
            in_data  = sent;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            if (VEC[i].ev) begin
                case (VEC[i].req)
                    4'd4:    check_out(sent, VEC[i].ex, "R4 value from other bank");
                    4'd5:    check_out(sent, VEC[i].ex, "R5 subtract");
                    default: check_out(sent, VEC[i].ex, "R6 passthrough");
                endcase
            end else begin
                chk(out_valid === 1'b0, "R3 no beat at ts 0", 32'(out_valid), 32'd0);
            end
            @(negedge clk);
        end

        // Backpressure: A pending, B waiting
        out_ready = 1'b0;
        in_data   = mk(32'd5, 12'd0, 12'hFFF, 32'd77, 20);
        in_valid  = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b1, "R8 A accepted", 32'(out_valid), 32'd1);
        chk(out_data[31:0] === 32'h8000_0000, "R4 A value", out_data[31:0], 32'h8000_0000);
        sent    = mk(32'd6, 12'd0, 12'hFFF, 32'd88, 21);
        in_data = sent;
        snap    = out_data;
        chk(in_ready === 1'b0, "R8 stall while full", 32'(in_ready), 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid === 1'b1 && out_data === snap, "R7 hold",
                out_data[31:0], snap[31:0]);
            chk(in_ready === 1'b0, "R8 stall held", 32'(in_ready), 32'd0);
        end
        out_ready = 1'b1;
        #0.1;
        chk(in_ready === 1'b1, "R8 ready while draining", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check_out(sent, 32'd77, "R4 B reads bank written by A");
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 drained", 32'(out_valid), 32'd0);

        // Reset with a pending result
        out_ready = 1'b0;
        in_data   = mk(32'd8, 12'd0, 12'hFFF, 32'd5, 22);
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R8 pending before reset", 32'(out_valid), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid === 1'b0, "R9 reset drops pending", 32'(out_valid), 32'd0);
        chk(in_ready === 1'b1, "R9 ready after reset", 32'(in_ready), 32'd1);
        out_ready = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule